// File: doc/BRIEF.md
# Sequential Multiply/Divide Engine

This block is an iterative arithmetic engine for unsigned integers. It holds three 8-bit operand registers, called X, Y and Z. It multiplies Y by X, adds the starting content of Z, and leaves the 16-bit result in Z (high byte) and Y (low byte). It can also divide the 16-bit value Z:Y by X, leaving the quotient in Y and the remainder in Z. Multiply uses eight conditional-add-then-shift-right steps. Divide uses eight shift-left-then-conditional-subtract steps. X is never changed by either operation.

A host loads operands and a control word through one write channel. A write moves on the cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while an operation runs, so the host must hold the write until the engine is idle. A write offered while busy is not taken and has no effect. The control word selects the operation, can clear Y and Z before it starts, and sets the step pacing. Pacing is either one step per clock, or one step every 2, 4 or 8 clocks, chosen by a unit-count field. Any register, or a status byte, can be read at any time through a combinational read mux.

A divide whose quotient would not fit in 8 bits is caught before any step runs. This includes a zero divisor. In that case the engine only raises the overflow flag and pulses done.

Top module: `mdu_engine`

## Requirements
- R1: A write is taken on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_sel` selects the target: 00 = X, 01 = Z, 10 = Y, 11 = control word. `rd_sel` uses the same codes for reads, except that 11 returns the status byte: bit 0 is the overflow flag and bits 7:1 read 0.
- R2: `wr_ready` is 0 while `busy` is 1. A write offered in that time is not taken and changes no register.
- R3: Control bits 1:0 select the operation: 01 starts a multiply, 10 starts a divide, and 00 or 11 start nothing. When nothing starts, `busy` and `done` stay 0 and X, Y and Z keep their values.
- R4: Control bit 2 = 1 clears Z and control bit 3 = 1 clears Y. Both clears take effect in the same write, before any operation that write starts.
- R5: Multiply leaves Z:Y = X*Y + Z, using the values before the start, and leaves X unchanged.
- R6: Divide with Z < X leaves the quotient of (Z:Y)/X in Y and the remainder in Z. It clears the overflow flag and leaves X unchanged.
- R7: A divide started with Z >= X (this includes X = 0) sets the overflow flag. `busy` never rises, `done` pulses in the cycle after the control write, and Y and Z keep their values.
- R8: With control bit 7 = 0, `busy` is 1 for exactly 8 cycles after the control write. `done` is 1 for one cycle, the first cycle in which `busy` is 0 again.
- R9: With control bit 7 = 1, each step takes D clocks, so `busy` lasts 8*D cycles. D is set by bits 5:4: 11 gives D = 2, 10 gives D = 4, 01 gives D = 8, 00 gives D = 8.
- R10: The overflow flag holds its value until the next operation starts. Starting a multiply clears it.
- R11: After reset, X, Y and Z are 0, `busy`, `done` and the overflow flag are 0, and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Engine can take a write (idle) |
| wr_sel | input | 2 | Write target: X, Z, Y or control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: X, Z, Y or status |
| rd_data | output | 8 | Selected register or status byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Divide overflow flag |

## Verification
Each step works on the full Z:Y pair, so one wrong add, subtract or shift bit spreads into every later step. A bad step therefore appears as a wrong product, quotient or remainder the moment `done` pulses. A pacer or step counter that is off by one changes how long `busy` stays high. The bench counts those cycles against 8*D for every pacing setting. If the overflow compare is wrong, `busy` rises when it should not, or Y and Z change when they should not, and this shows on the first divide after the fault.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned MDU_W = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_MUL  = 2'b01,
    OP_DIV  = 2'b10,
    OP_BAD  = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    SEL_X   = 2'b00,
    SEL_Z   = 2'b01,
    SEL_Y   = 2'b10,
    SEL_CTL = 2'b11
  } mdu_sel_e;

  // control word bit positions
  localparam int unsigned CB_CLR_Z = 2;
  localparam int unsigned CB_CLR_Y = 3;
  localparam int unsigned CB_UNIT0 = 4;
  localparam int unsigned CB_SLOW  = 7;

  // log2 of the per-step clock divide for a unit-count code
  function automatic logic [1:0] pace_log2(input logic [1:0] units);
    case (units)
      2'b11:   pace_log2 = 2'd1;
      2'b10:   pace_log2 = 2'd2;
      default: pace_log2 = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/mdu_pacer.sv
module mdu_pacer #(
  parameter int unsigned CW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       cfg_slow,
  input  logic [1:0] cfg_units,
  input  logic       start,
  input  logic       run,
  output logic       tick
);
  import mdu_pkg::*;

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic          slow_q;
  logic [1:0]    lg_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      lg_q   <= 2'd0;
    end else if (cfg_load) begin
      slow_q <= cfg_slow;
      lg_q   <= pace_log2(cfg_units);
    end
  end

  always_comb begin
    limit = (ONE << lg_q) - ONE;
    tick  = run && (!slow_q || (cnt_q == limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start || !run || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int unsigned STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_mul,
  input  logic start_div,
  input  logic div_ovf,
  input  logic tick,
  output logic busy,
  output logic done,
  output logic ovf,
  output logic is_div,
  output logic step
);
  localparam int unsigned SCW = $clog2(STEPS + 1);
  localparam logic [SCW-1:0] LAST = SCW'(STEPS - 1);

  logic [SCW-1:0] cnt_q;

  assign step = busy && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      ovf    <= 1'b0;
      is_div <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start_mul) begin
        busy   <= 1'b1;
        is_div <= 1'b0;
        ovf    <= 1'b0;
        cnt_q  <= '0;
      end else if (start_div) begin
        cnt_q <= '0;
        if (div_ovf) begin
          ovf  <= 1'b1;
          done <= 1'b1;
        end else begin
          ovf    <= 1'b0;
          busy   <= 1'b1;
          is_div <= 1'b1;
        end
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_x,
  input  logic         wr_y,
  input  logic         wr_z,
  input  logic [W-1:0] wr_data,
  input  logic         clr_y,
  input  logic         clr_z,
  input  logic         step,
  input  logic         is_div,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] z_q,
  output logic         div_ovf
);
  logic [W:0]   sum;
  logic [W:0]   rem_sh;
  logic [W:0]   rem_sub;
  logic         fits;
  logic [W-1:0] z_step;
  logic [W-1:0] y_step;

  always_comb begin
    div_ovf = (clr_z ? '0 : z_q) >= x_q;
    sum     = {1'b0, z_q} + (y_q[0] ? {1'b0, x_q} : '0);
    rem_sh  = {z_q, y_q[W-1]};
    rem_sub = rem_sh - {1'b0, x_q};
    fits    = rem_sh >= {1'b0, x_q};
    if (is_div) begin
      z_step = fits ? rem_sub[W-1:0] : rem_sh[W-1:0];
      y_step = {y_q[W-2:0], fits};
    end else begin
      z_step = sum[W:1];
      y_step = {sum[0], y_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else begin
      if (wr_x) x_q <= wr_data;
      if (step) begin
        y_q <= y_step;
        z_q <= z_step;
      end else begin
        if (wr_y)       y_q <= wr_data;
        else if (clr_y) y_q <= '0;
        if (wr_z)       z_q <= wr_data;
        else if (clr_z) z_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
  import mdu_pkg::*;
#(
  parameter int unsigned W     = MDU_W,
  parameter int unsigned STEPS = MDU_W,
  parameter int unsigned PCW   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         done,
  output logic         ovf
);
  logic         take;
  logic         ctl_wr;
  logic         start_mul;
  logic         start_div;
  logic         div_ovf;
  logic         tick;
  logic         step;
  logic         is_div;
  logic [W-1:0] dp_x;
  logic [W-1:0] dp_y;
  logic [W-1:0] dp_z;

  assign wr_ready  = !busy;
  assign take      = wr_valid && wr_ready;
  assign ctl_wr    = take && (mdu_sel_e'(wr_sel) == SEL_CTL);
  assign start_mul = ctl_wr && (mdu_op_e'(wr_data[1:0]) == OP_MUL);
  assign start_div = ctl_wr && (mdu_op_e'(wr_data[1:0]) == OP_DIV);

  mdu_pacer #(.CW(PCW)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (ctl_wr),
    .cfg_slow  (wr_data[CB_SLOW]),
    .cfg_units (wr_data[CB_UNIT0 +: 2]),
    .start     (start_mul || start_div),
    .run       (busy),
    .tick      (tick)
  );

  mdu_seq #(.STEPS(STEPS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_mul (start_mul),
    .start_div (start_div),
    .div_ovf   (div_ovf),
    .tick      (tick),
    .busy      (busy),
    .done      (done),
    .ovf       (ovf),
    .is_div    (is_div),
    .step      (step)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_x    (take && (mdu_sel_e'(wr_sel) == SEL_X)),
    .wr_y    (take && (mdu_sel_e'(wr_sel) == SEL_Y)),
    .wr_z    (take && (mdu_sel_e'(wr_sel) == SEL_Z)),
    .wr_data (wr_data),
    .clr_y   (ctl_wr && wr_data[CB_CLR_Y]),
    .clr_z   (ctl_wr && wr_data[CB_CLR_Z]),
    .step    (step),
    .is_div  (is_div),
    .x_q     (dp_x),
    .y_q     (dp_y),
    .z_q     (dp_z),
    .div_ovf (div_ovf)
  );

  always_comb begin
    case (mdu_sel_e'(rd_sel))
      SEL_X:   rd_data = dp_x;
      SEL_Z:   rd_data = dp_z;
      SEL_Y:   rd_data = dp_y;
      default: rd_data = {{(W-1){1'b0}}, ovf};
    endcase
  end
endmodule

// File: rtl/mdu_checks.sv
module mdu_checks #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic [W-1:0] x_val
);
  // R8: completion pulse comes with the fall of busy
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: done never overlaps a running operation
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5 / R6: X is held across a running operation
  a_r5_x_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(x_val));

  // R7: overflow only appears together with a completion pulse
  a_r7_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> done);
endmodule

bind mdu_engine mdu_checks #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .ovf   (ovf),
  .x_val (dp_x)
);

// File: tb/sim_mdu_engine.sv
module sim_mdu_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_sel = 2'b00;
  logic [7:0] rd_data;
  logic       busy, done, ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdu_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy), .done(done), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_sel = sel; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  // waits from the negedge after a control write until done or idle
  task automatic wait_op(output int nbusy, output bit seen);
    nbusy = 0; seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1; break; end
      if (!busy) break;
      nbusy++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_cycles(input logic [7:0] c);
    if (!c[7]) return 8;
    case (c[5:4])
      2'b11: return 16;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic run_case(input logic [7:0] x, input logic [7:0] y,
                          input logic [7:0] z, input logic [7:0] ctl);
    logic [15:0] dvd, prod;
    logic [7:0] ex_y, ex_z, gy, gz, gx, gs;
    bit ex_ovf, seen;
    int nb, ecyc;
    wr(2'b00, x); wr(2'b10, y); wr(2'b01, z);
    if (ctl[3]) y = 8'h00;
    if (ctl[2]) z = 8'h00;
    dvd = {z, y};
    ecyc = exp_cycles(ctl);
    if (ctl[1:0] == 2'b01) begin
      prod = 16'(x * y) + 16'(z);
      ex_z = prod[15:8]; ex_y = prod[7:0]; ex_ovf = 0;
    end else if (z >= x) begin
      ex_z = z; ex_y = y; ex_ovf = 1; ecyc = 0;
    end else begin
      ex_y = 8'(dvd / x); ex_z = 8'(dvd % x); ex_ovf = 0;
    end
    wr(2'b11, ctl);
    wait_op(nb, seen);
    check(seen, "R8 done pulse", int'(seen), 1);
    check(nb == ecyc, ex_ovf ? "R7 busy cycles" : (ctl[7] ? "R9 busy cycles" : "R8 busy cycles"), nb, ecyc);
    @(negedge clk);
    check(!done, "R8 done one cycle", int'(done), 0);
    rd(2'b00, gx); rd(2'b10, gy); rd(2'b01, gz); rd(2'b11, gs);
    check(gx == x, "R5 X kept", gx, x);
    check(gy == ex_y, ctl[1] ? "R6 Y quotient" : "R5 Y low", gy, ex_y);
    check(gz == ex_z, ctl[1] ? "R6 Z remainder" : "R5 Z high", gz, ex_z);
    check(gs == {7'd0, ex_ovf}, "R7 status", gs, {7'd0, ex_ovf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    bit seen;
    int nb;
    void'($urandom(32'd1855));
    repeat (3) @(negedge clk);
    // R11 reset state
    rd(2'b00, v); check(v == 0, "R11 X", v, 0);
    rd(2'b01, v); check(v == 0, "R11 Z", v, 0);
    rd(2'b10, v); check(v == 0, "R11 Y", v, 0);
    check(!busy && !done && !ovf, "R11 flags", {busy, done, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready, "R11 ready", wr_ready, 1);

    // R1 write and read back
    wr(2'b00, 8'h5A); wr(2'b01, 8'hC3); wr(2'b10, 8'h81);
    rd(2'b00, v); check(v == 8'h5A, "R1 X", v, 8'h5A);
    rd(2'b01, v); check(v == 8'hC3, "R1 Z", v, 8'hC3);
    rd(2'b10, v); check(v == 8'h81, "R1 Y", v, 8'h81);

    // R3 no-op and illegal codes start nothing
    wr(2'b11, 8'h00);
    wait_op(nb, seen); check(!seen && nb == 0, "R3 code 00", nb, 0);
    wr(2'b11, 8'h03);
    wait_op(nb, seen); check(!seen && nb == 0, "R3 code 11", nb, 0);
    repeat (4) @(negedge clk);
    check(!busy && !done, "R3 idle", busy, 0);
    rd(2'b10, v); check(v == 8'h81, "R3 Y kept", v, 8'h81);
    rd(2'b01, v); check(v == 8'hC3, "R3 Z kept", v, 8'hC3);

    // R4 clear bits with no operation
    wr(2'b11, 8'h0C);
    rd(2'b10, v); check(v == 0, "R4 Y cleared", v, 0);
    rd(2'b01, v); check(v == 0, "R4 Z cleared", v, 0);

    // directed corners
    run_case(8'hFF, 8'hFF, 8'hFF, 8'h31);   // R5 max MAC, rate 1
    run_case(8'h07, 8'h09, 8'h55, 8'h35);   // R4 clear Z then multiply
    run_case(8'h10, 8'hAA, 8'h22, 8'hBA);   // R7 overflow Z>=X
    run_case(8'h00, 8'h12, 8'h00, 8'h32);   // R7 zero divisor
    run_case(8'hFF, 8'hFF, 8'hFE, 8'h32);   // R6 max quotient
    run_case(8'h03, 8'h40, 8'h02, 8'hF2);   // R9 D=2
    run_case(8'h03, 8'h40, 8'h02, 8'hE1);   // R9 D=4
    run_case(8'h03, 8'h40, 8'h02, 8'hD1);   // R9 D=8
    run_case(8'h03, 8'h40, 8'h02, 8'hC2);   // R9 D=8

    // R10 multiply clears a held overflow
    run_case(8'h01, 8'h01, 8'h05, 8'h32);
    rd(2'b11, v); check(v == 8'h01, "R10 ovf held", v, 1);
    repeat (3) @(negedge clk);
    check(ovf, "R10 ovf still held", ovf, 1);
    run_case(8'h02, 8'h03, 8'h00, 8'h31);
    check(!ovf, "R10 ovf cleared by multiply", ovf, 0);

    // R2 write refused while busy
    wr(2'b00, 8'h0B); wr(2'b10, 8'h0D); wr(2'b01, 8'h00);
    wr(2'b11, 8'hF1);
    @(negedge clk);
    wr_sel = 2'b00; wr_data = 8'hEE; wr_valid = 1'b1;
    check(!wr_ready, "R2 ready low", wr_ready, 0);
    @(negedge clk);
    wr_sel = 2'b10;
    @(negedge clk);
    wr_valid = 1'b0;
    wait_op(nb, seen);
    @(negedge clk);
    rd(2'b00, v); check(v == 8'h0B, "R2 X not written", v, 8'h0B);
    rd(2'b10, v2); check(v2 == 8'h8F, "R2 Y not written", v2, 8'h8F);

    // random mix
    for (int k = 0; k < 250; k++) begin
      logic [7:0] rx, ry, rz, rc;
      rx = 8'($urandom); ry = 8'($urandom); rz = 8'($urandom);
      rc = 8'($urandom) & 8'hFC;
      rc[1:0] = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      if (rc[1] && ($urandom % 4 != 0)) rz = (rx == 0) ? 8'h00 : 8'(rz % rx);
      run_case(rx, ry, rz, rc);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule